// File: doc/BRIEF.md
# Pipelined Late-Write Burst SRAM

This block is a synchronous single-port memory with 72-bit words. Each word has eight 9-bit byte lanes. The depth is set by a parameter and kept small. Every input is registered on the rising clock edge. Read data appears two cycles after its address. Write data is taken two cycles after its address. Because both directions have the same latency, the data bus can switch between reads and writes on consecutive cycles with no idle cycle in between.

A new cycle starts when the advance input `adv` is low. That cycle is a read, a write or a deselect, decided by `we_n` and the three chip enables. When `adv` is high, the block keeps the operation already in progress and steps to the next address of a four-beat burst. A static input picks a linear or an interleaved burst order. Two of the chip enables have their active level set by static polarity inputs.

The burst controller is a state machine with three states:
- `OP_DESEL`: idle.
- `OP_READ`: read burst in progress.
- `OP_WRITE`: write burst in progress.

Its transitions are:
- `LOAD_RD`: `adv` low, enables active, `we_n` high; goes to `OP_READ`.
- `LOAD_WR`: `adv` low, enables active, `we_n` low; goes to `OP_WRITE`.
- `LOAD_OFF`: `adv` low, enables inactive; goes to `OP_DESEL`.
- `ADVANCE`: `adv` high; stays in the current state and moves to the next burst address.

Top module: `nbt_sram`

## Requirements
- R1: While reset is held and after it is released, `rvalid` is 0 and `rdata` is all zeros until a read is due.
- R2: When a load cycle (`adv`=0) has the enables active and `we_n`=1, it is a read. The addressed word is on `rdata` with `rvalid`=1 after the second rising edge that follows the address edge.
- R3: When a load cycle has the enables active and `we_n`=0, it is a write. `wdata` is captured at the second rising edge after the address edge. Lane i (bits 9i+8 down to 9i) is written only when `lane_we_n[i]` was 0 at the address edge of that beat.
- R4: With `burst_ileave`=0, beat k of a burst (the load is beat 0) uses address bits [1:0] = (start + k) mod 4. The upper address bits are unchanged.
- R5: With `burst_ileave`=1, beat k uses address bits [1:0] = start XOR (k mod 4). The upper address bits are unchanged.
- R6: The enables are active only when all three hold: `ce0_n`=0, `ce1`==`ce1_pol` and `ce2`==`ce2_pol`. A polarity input of 1 means active-high. A load with the enables inactive is a deselect. A deselect changes no memory word and produces no read data.
- R7: On an advance cycle, `we_n` and the chip enables are ignored and the burst keeps its operation. An advance after a deselect stays deselected.
- R8: Reads and writes may alternate on every cycle. Every read returns the data of all writes issued before it.
- R9: A read issued one cycle after a write to the same address returns the new data in the lanes that write enabled. It returns the older contents in the other lanes.
- R10: Whenever no read data is due, `rdata` is zero and `rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address, used on load cycles |
| adv | input | 1 | 0 = load a new cycle, 1 = advance the current burst |
| we_n | input | 1 | 0 = write, 1 = read (used on load cycles) |
| lane_we_n | input | LANES | Active-low write enable per 9-bit lane |
| ce0_n | input | 1 | Chip enable, always active-low |
| ce1 | input | 1 | Chip enable with programmable sense |
| ce2 | input | 1 | Chip enable with programmable sense |
| ce1_pol | input | 1 | Static: 1 makes `ce1` active-high, 0 active-low |
| ce2_pol | input | 1 | Static: 1 makes `ce2` active-high, 0 active-low |
| burst_ileave | input | 1 | Static: 0 = linear order, 1 = interleaved order |
| wdata | input | LANES*LANE_W | Write data, sampled two edges after its address |
| rdata | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid | output | 1 | High while `rdata` carries read data |

## Verification
The bench first fills the whole array with single-beat writes and reads it back. This ties each address to its own data pattern. A phase that alternates writes and reads every cycle shows whether the equal read and write latency really avoids a turnaround gap. A write followed at once by a read of the same address, with one lane enabled at a time, separates a correct lane-wise merge of pending data from a stale read. Bursts from every start offset in both orders tell wrap arithmetic from plain increment. A sweep over all eight enable combinations and all four polarity settings checks the enable decode. Advance beats with changed enables and read/write show that a running burst, or a deselect, ignores those inputs.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

    typedef enum logic [1:0] {
        OP_DESEL = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // two low address bits of burst beat cnt starting at start
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] cnt,
                                             input logic       ileave);
        return ileave ? (start ^ cnt) : (start + cnt);
    endfunction

endpackage

// File: rtl/nbt_burst_ctrl.sv
module nbt_burst_ctrl
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              sel,
    input  logic              wr_n,
    input  logic              ileave,
    input  logic [ADDR_W-1:0] addr,
    output op_e               op_q,
    output logic [ADDR_W-1:0] addr_q
);

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic [1:0]        cnt_nx;
    op_e               op_nx;
    logic [ADDR_W-1:0] addr_nx;

    // next-state logic: LOAD_RD / LOAD_WR / LOAD_OFF when adv low, ADVANCE otherwise
    always_comb begin
        cnt_nx = cnt_q + 2'd1;
        if (!adv) begin
            if (!sel)      op_nx = OP_DESEL;
            else if (wr_n) op_nx = OP_READ;
            else           op_nx = OP_WRITE;
            addr_nx = addr;
        end else begin
            unique case (op_q)
                OP_DESEL: op_nx = OP_DESEL;
                OP_READ:  op_nx = OP_READ;
                OP_WRITE: op_nx = OP_WRITE;
                default:  op_nx = OP_DESEL;
            endcase
            addr_nx = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_nx, ileave)};
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_DESEL;
            addr_q <= '0;
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            op_q   <= op_nx;
            addr_q <= addr_nx;
            if (!adv) begin
                base_q <= addr;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_nx;
            end
        end
    end

    a_r7_adv_holds_op: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (op_q == $past(op_q)));

    a_r4_adv_keeps_group: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2])));

    a_r6_off_load_desel: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !sel) |=> (op_q == OP_DESEL));

endmodule

// File: rtl/nbt_lane_array.sv
module nbt_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 8,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [LANES*LANE_W-1:0]   rd_q,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANES-1:0]          wr_lane,
    input  logic [LANES*LANE_W-1:0]   wr_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (wr_en && wr_lane[g]) begin
                mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
            lane_q <= mem[rd_addr];
        end

        assign rd_q[g*LANE_W +: LANE_W] = lane_q;
    end

endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 8,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     adv,
    input  logic                     we_n,
    input  logic [LANES-1:0]         lane_we_n,
    input  logic                     ce0_n,
    input  logic                     ce1,
    input  logic                     ce2,
    input  logic                     ce1_pol,
    input  logic                     ce2_pol,
    input  logic                     burst_ileave,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic                     rvalid
);

    localparam int DATA_W = LANES * LANE_W;

    logic              sel;
    op_e               s1_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_lane_n;
    op_e               s2_op;
    logic [ADDR_W-1:0] s2_addr;
    logic [LANES-1:0]  s2_lane_n;
    logic [DATA_W-1:0] arr_q;
    logic              byp_hit_q;
    logic [DATA_W-1:0] byp_data_q;
    logic [LANES-1:0]  byp_lane_n_q;
    logic [DATA_W-1:0] merged;

    assign sel = !ce0_n && (ce1 == ce1_pol) && (ce2 == ce2_pol);

    nbt_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .sel    (sel),
        .wr_n   (we_n),
        .ileave (burst_ileave),
        .addr   (addr),
        .op_q   (s1_op),
        .addr_q (s1_addr)
    );

    nbt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .rd_addr (s1_addr),
        .rd_q    (arr_q),
        .wr_en   (s2_op == OP_WRITE),
        .wr_addr (s2_addr),
        .wr_lane (~s2_lane_n),
        .wr_data (wdata)
    );

    // pipeline stage two and pending-write capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_lane_n    <= '1;
            s2_op        <= OP_DESEL;
            s2_addr      <= '0;
            s2_lane_n    <= '1;
            byp_hit_q    <= 1'b0;
            byp_data_q   <= '0;
            byp_lane_n_q <= '1;
        end else begin
            s1_lane_n    <= lane_we_n;
            s2_op        <= s1_op;
            s2_addr      <= s1_addr;
            s2_lane_n    <= s1_lane_n;
            byp_hit_q    <= (s1_op == OP_READ) && (s2_op == OP_WRITE) && (s1_addr == s2_addr);
            byp_data_q   <= wdata;
            byp_lane_n_q <= s2_lane_n;
        end
    end

    always_comb begin
        for (int g = 0; g < LANES; g++) begin
            merged[g*LANE_W +: LANE_W] = (byp_hit_q && !byp_lane_n_q[g])
                                       ? byp_data_q[g*LANE_W +: LANE_W]
                                       : arr_q[g*LANE_W +: LANE_W];
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (s2_op == OP_READ) begin
            rvalid <= 1'b1;
            rdata  <= merged;
        end else begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end
    end

    a_r2_read_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_op == OP_READ) |=> rvalid);

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0));

    a_r9_hit_is_read: assert property (@(posedge clk) disable iff (!rst_n)
        byp_hit_q |-> (s2_op == OP_READ));

endmodule

// File: tb/nbt_sram_tb.sv
module nbt_sram_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        adv = 1'b0;
    logic        we_n = 1'b1;
    logic [7:0]  lane_we_n = '1;
    logic        ce0_n = 1'b1;
    logic        ce1 = 1'b0;
    logic        ce2 = 1'b0;
    logic        ce1_pol = 1'b1;
    logic        ce2_pol = 1'b1;
    logic        burst_ileave = 1'b0;
    logic [71:0] wdata = '0;
    logic [71:0] rdata;
    logic        rvalid;

    always #2 clk = ~clk;

    nbt_sram u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adv(adv), .we_n(we_n),
        .lane_we_n(lane_we_n), .ce0_n(ce0_n), .ce1(ce1), .ce2(ce2),
        .ce1_pol(ce1_pol), .ce2_pol(ce2_pol), .burst_ileave(burst_ileave),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    // configuration applied on the next step
    bit cfg_il = 0, cfg_p1 = 1, cfg_p2 = 1;

    logic [71:0] ref_mem [64];
    int          q_op   [8];   // 0 deselect, 1 read, 2 write
    logic [5:0]  q_addr [8];
    logic [7:0]  q_mask [8];
    logic [71:0] q_exp  [8];
    string       q_tag  [8];

    int         m_op = 0;
    logic [5:0] m_base = '0;
    logic [1:0] m_cnt = '0;

    function automatic logic [71:0] make_wd(input int j);
        logic [71:0] r;
        for (int l = 0; l < 8; l++) r[l*9 +: 9] = 9'((j*29 + l*83 + 17) % 512);
        return r;
    endfunction

    task automatic step(input bit ld, input bit wn, input int a, input logic [7:0] m,
                        input bit c0n, input bit c1v, input bit c2v, input string tag);
        int k;
        logic [5:0]  ea;
        logic [1:0]  low;
        logic [71:0] wd;
        logic [71:0] exp_d;
        bit          exp_v;
        @(negedge clk);
        if (cyc >= 3) begin
            k = (cyc - 3) % 8;
            exp_v = (q_op[k] == 1);
            exp_d = exp_v ? q_exp[k] : '0;
            checks++;
            if (rvalid !== exp_v || rdata !== exp_d) begin
                errors++;
                $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                         q_tag[k], rvalid, rdata, exp_v, exp_d);
            end
        end
        if (cyc >= 2) begin
            k = (cyc - 2) % 8;
            wd = make_wd(cyc);
            wdata = wd;
            if (q_op[k] == 2) begin
                for (int l = 0; l < 8; l++)
                    if (!q_mask[k][l]) ref_mem[q_addr[k]][l*9 +: 9] = wd[l*9 +: 9];
            end else if (q_op[k] == 1) begin
                q_exp[k] = ref_mem[q_addr[k]];
            end
        end
        adv = !ld; we_n = wn; addr = 6'(a); lane_we_n = m;
        ce0_n = c0n; ce1 = c1v; ce2 = c2v;
        ce1_pol = cfg_p1; ce2_pol = cfg_p2; burst_ileave = cfg_il;
        if (ld) begin
            m_op = (!c0n && c1v == cfg_p1 && c2v == cfg_p2) ? (wn ? 1 : 2) : 0;
            m_base = 6'(a); m_cnt = 2'd0; ea = 6'(a);
        end else begin
            m_cnt = m_cnt + 2'd1;
            low = cfg_il ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
            ea = {m_base[5:2], low};
        end
        k = cyc % 8;
        q_op[k] = m_op; q_addr[k] = ea; q_mask[k] = m; q_tag[k] = tag;
        cyc++;
    endtask

    task automatic op(input bit ld, input bit wn, input int a, input logic [7:0] m,
                      input string tag);
        step(ld, wn, a, m, 1'b0, cfg_p1, cfg_p2, tag);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        checks++;   // R1 during reset
        if (rvalid !== 1'b0 || rdata !== '0) begin
            errors++;
            $display("FAIL R1: rvalid=%0b rdata=%h expected rvalid=0 rdata=0", rvalid, rdata);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) step(1, 1, 0, 8'hFF, 1, 0, 0, "R1");

        // R3 fill, R2 read back
        for (int a = 0; a < 64; a++) op(1, 0, a, 8'h00, "R3");
        for (int a = 0; a < 64; a++) op(1, 1, a, 8'hFF, "R2");

        // R8 write/read alternating every cycle
        for (int a = 0; a < 64; a++) begin
            op(1, 0, a, 8'h00, "R8");
            op(1, 1, (a + 32) % 64, 8'hFF, "R8");
        end

        // R9 read right after a one-lane write to the same address (also R3 lanes)
        for (int a = 0; a < 16; a++) begin
            op(1, 0, a, ~(8'h01 << (a % 8)), "R9");
            op(1, 1, a, 8'hFF, "R9");
        end

        // R4 linear bursts from every start; R7 advance ignores we_n/enables
        cfg_il = 0;
        for (int s = 0; s < 8; s++) begin
            op(1, 0, 16 + s, 8'h00, "R4");
            for (int b = 0; b < 3; b++) op(0, 0, 0, (b == 1) ? 8'hF0 : 8'h00, "R4");
            op(1, 1, 16 + s, 8'hFF, "R4");
            for (int b = 0; b < 7; b++) step(0, 0, 0, 8'h00, 1, !cfg_p1, !cfg_p2, "R7");
        end

        // R5 interleaved bursts: write from each start, read from each start
        cfg_il = 1;
        for (int s = 0; s < 4; s++) begin
            op(1, 0, 32 + s, 8'h00, "R5");
            for (int b = 0; b < 3; b++) op(0, 0, 0, 8'h00, "R5");
            for (int r = 0; r < 4; r++) begin
                op(1, 1, 32 + r, 8'hFF, "R5");
                for (int b = 0; b < 3; b++) op(0, 1, 0, 8'hFF, "R5");
            end
        end
        cfg_il = 0;

        // R6 polarity x enable sweep
        for (int p = 0; p < 4; p++) begin
            cfg_p1 = p[0]; cfg_p2 = p[1];
            for (int c = 0; c < 8; c++) begin
                step(1, 0, 48 + c, 8'h00, c[0], c[1], c[2], "R6");
                step(1, 1, 48 + c, 8'hFF, c[0], c[1], c[2], "R6");
            end
        end
        cfg_p1 = 1; cfg_p2 = 0;
        for (int c = 0; c < 8; c++) op(1, 1, 48 + c, 8'hFF, "R6");

        // R7 advance after deselect stays deselected
        step(1, 0, 40, 8'h00, 1, cfg_p1, cfg_p2, "R7");
        for (int b = 0; b < 3; b++) op(0, 0, 0, 8'h00, "R7");
        for (int a = 40; a < 44; a++) op(1, 1, a, 8'hFF, "R7");

        // R10 idle flush
        for (int i = 0; i < 5; i++) step(1, 1, 0, 8'hFF, 1, 0, 0, "R10");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule